// File: doc/BRIEF.md
# Stack Data Cache with Dead-Space and Fresh-Space Pointers

This block is a small direct-mapped data cache that serves stack loads and stores only. It is indexed and tagged with the virtual address, so its lookup needs no translation. Each line carries a valid bit and a dirty bit. A miss holds off the requester until any needed memory traffic has finished. Memory traffic always moves a whole line, at a line-aligned address.

Two pointer registers follow the stack, which grows toward lower addresses. The live boundary `tos` marks the current top of the stack. The fresh boundary `srb` marks the upper end of space that has been newly pushed since the last return. A call event loads `tos` from `sp_new` and leaves `srb` as it was. A return event loads both registers from `sp_new`.

The pointers affect only what happens on a miss. A dirty victim whose whole line sits below `tos` is dead data, so it is dropped without a write-back. A store miss to a line that lies entirely within `[tos, srb)` installs a zeroed line without reading memory.

Top module: `stack_cache`

## Requirements
- R1: A load hit returns the most recently stored value of that word. `rsp_valid` is high for exactly one cycle, two cycles after the accepting clock edge, and the hit causes no memory traffic.
- R2: A load miss reads the line from memory. Memory traffic always has `mem_addr` aligned to 32 bytes. The response carries the requested word of the data returned by memory.
- R3: Before the new line is fetched or installed, a dirty victim is written to memory at its own line address with its full contents, unless its line is dead.
- R4: A victim line is dead when its last byte lies below `tos`, that is, when line base + 32 <= `tos`. A dead dirty victim is dropped with no memory write.
- R5: A store miss to a line with base >= `tos` and base + 32 <= `srb` performs no memory read. The stored word is written, and every other word of that line reads as zero. A store hit in that same region leaves the other words unchanged.
- R6: A store miss outside that region reads the line from memory and merges the stored word into it. The other words keep their memory values.
- R7: `call_evt` sets `tos` to `sp_new` and leaves `srb` unchanged. `ret_evt` sets both `tos` and `srb` to `sp_new`. If both are high in the same cycle, the call takes priority. Both registers reset to 0.
- R8: A clean victim is replaced without any memory write.
- R9: `req_ready` is low from the accepting edge until the response. While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_write` hold steady.
- R10: After reset, `req_ready` is high and both `mem_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Cache idle and able to accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Virtual byte address (word aligned) |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data (meaningful for loads) |
| call_evt | input | 1 | Call event |
| ret_evt | input | 1 | Return event |
| sp_new | input | 32 | Stack pointer carried by a call or return |
| mem_valid | output | 1 | Memory line transfer request |
| mem_ready | input | 1 | Memory transfer complete |
| mem_write | output | 1 | 1 = write-back, 0 = line fill |
| mem_addr | output | 32 | Line-aligned byte address |
| mem_wdata | output | 256 | Write-back line |
| mem_rdata | input | 256 | Fill line |

## Verification
The hardest situation to reach is a dirty victim that changes from live to dead between being written and being evicted. Reaching it takes three steps in order. First, a store lands in a line above `tos`. Second, a return must move `tos` past that whole line. Third, a conflicting access must later reach the same index. The directed part of the stimulus builds this exact sequence. It also covers the partner case, where the same line is evicted while still live and must be written back. The random phase then interleaves calls and returns with arbitrary, word-granular stack pointers among loads and stores confined to a 4 KB window. This drives victims to straddle `tos` and drives store misses to sit on the edges of the fresh region.

// File: rtl/stack_cache.sv
module stack_cache #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CACHE_BYTES = 1024,
  parameter int LINE_BYTES  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  input  logic                    call_evt,
  input  logic                    ret_evt,
  input  logic [ADDR_W-1:0]       sp_new,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_write,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);
  localparam int LINES  = CACHE_BYTES / LINE_BYTES;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WPL    = LINE_BYTES / (DATA_W / 8);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WSEL_W = $clog2(WPL);
  localparam int BOFF   = $clog2(DATA_W / 8);
  localparam logic [ADDR_W:0] LSPAN = (ADDR_W+1)'(LINE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WB, S_FILL} state_t;
  state_t state;

  logic [ADDR_W-1:0] a_q, tos_q, srb_q;
  logic              we_q, skip_q;
  logic [DATA_W-1:0] wd_q;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [LINE_W-1:0] line_q [LINES];
  logic [LINES-1:0]  vld_q, dty_q;

  wire [IDX_W-1:0]  idx  = a_q[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  tag  = a_q[ADDR_W-1 -: TAG_W];
  wire [WSEL_W-1:0] wsel = a_q[BOFF +: WSEL_W];
  wire [ADDR_W-1:0] base = {a_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  wire [ADDR_W-1:0] vic_base = {tag_q[idx], idx, {OFF_W{1'b0}}};

  wire hit      = vld_q[idx] && (tag_q[idx] == tag);
  wire vic_dead = ({1'b0, vic_base} + LSPAN) <= {1'b0, tos_q};
  wire safe     = we_q && (base >= tos_q) && (({1'b0, base} + LSPAN) <= {1'b0, srb_q});
  wire need_wb  = vld_q[idx] && dty_q[idx] && !vic_dead;

  logic              inst;
  logic [LINE_W-1:0] inst_src, base_line, merged;

  always_comb begin
    inst     = 1'b0;
    inst_src = '0;
    case (state)
      S_LOOK: inst = !hit && !need_wb && safe;
      S_WB:   inst = mem_ready && skip_q;
      S_FILL: begin inst = mem_ready; inst_src = mem_rdata; end
      default: ;
    endcase
    base_line = inst ? inst_src : line_q[idx];
    merged    = base_line;
    if (we_q) merged[wsel*DATA_W +: DATA_W] = wd_q;
  end

  wire done = (state == S_LOOK && hit) || inst;

  assign req_ready = (state == S_IDLE);
  assign mem_valid = (state == S_WB) || (state == S_FILL);
  assign mem_write = (state == S_WB);
  assign mem_addr  = (state == S_WB) ? vic_base : base;
  assign mem_wdata = line_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      a_q       <= '0;
      we_q      <= 1'b0;
      wd_q      <= '0;
      skip_q    <= 1'b0;
      vld_q     <= '0;
      dty_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      tos_q     <= '0;
      srb_q     <= '0;
    end else begin
      if (call_evt) tos_q <= sp_new;
      else if (ret_evt) begin
        tos_q <= sp_new;
        srb_q <= sp_new;
      end
      rsp_valid <= done;
      if (done) begin
        rsp_rdata <= base_line[wsel*DATA_W +: DATA_W];
        if (inst) begin
          vld_q[idx] <= 1'b1;
          dty_q[idx] <= we_q;
        end else if (we_q) dty_q[idx] <= 1'b1;
      end
      case (state)
        S_IDLE: if (req_valid) begin
          a_q   <= req_addr;
          we_q  <= req_write;
          wd_q  <= req_wdata;
          state <= S_LOOK;
        end
        S_LOOK: begin
          if (hit) state <= S_IDLE;
          else if (need_wb) begin
            skip_q <= safe;
            state  <= S_WB;
          end else if (safe) state <= S_IDLE;
          else state <= S_FILL;
        end
        S_WB:   if (mem_ready) state <= skip_q ? S_IDLE : S_FILL;
        S_FILL: if (mem_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (done && (inst || we_q)) begin
      line_q[idx] <= merged;
      if (inst) tag_q[idx] <= tag;
    end
  end

  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));
  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  a_r1_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[OFF_W-1:0] == '0);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid);
endmodule

// File: tb/stack_cache_test.sv
module stack_cache_test;
  localparam int BASE_A = 32'h1000;
  localparam int NL     = 128;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, call_evt = 0, ret_evt = 0, mem_ready = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, sp_new = 0;
  logic req_ready, rsp_valid, mem_valid, mem_write;
  logic [31:0] rsp_rdata, mem_addr;
  logic [255:0] mem_wdata, mem_rdata = '0;

  always #10 clk = ~clk;

  stack_cache uut (.*);

  int total = 0, bad = 0;
  int wb_cnt = 0, fill_cnt = 0, dly = 0;
  logic [31:0] wb_last = 0;
  logic [255:0] mem_m [NL];
  logic [255:0] ref_mem [NL];
  logic [255:0] r_line [32];
  logic [21:0]  r_tag [32];
  logic [31:0]  r_vld = 0, r_dty = 0;
  logic [31:0]  r_tos = 0, r_srb = 0;

  function automatic logic [255:0] init_line(int i);
    logic [255:0] l;
    for (int j = 0; j < 8; j++) l[j*32 +: 32] = 32'hA5A5_0000 ^ {16'(i), 16'(j)};
    return l;
  endfunction

  function automatic int li(logic [31:0] a);
    return int'((a - BASE_A) >> 5);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_ready) mem_ready <= 1'b0;
    else if (mem_valid) begin
      if (dly >= 1 + (mem_addr[7:5] % 3)) begin
        dly <= 0;
        mem_ready <= 1'b1;
        if (li(mem_addr) < 0 || li(mem_addr) >= NL) begin
          bad++;
          $display("FAIL R2 address range: actual=%h expected=in window", mem_addr);
        end else if (mem_write) begin
          mem_m[li(mem_addr)] <= mem_wdata;
          wb_cnt <= wb_cnt + 1;
          wb_last <= mem_addr;
        end else begin
          mem_rdata <= mem_m[li(mem_addr)];
          fill_cnt <= fill_cnt + 1;
        end
      end else dly <= dly + 1;
    end
  end

  task automatic ref_access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                            output logic [31:0] erd, output bit ehit, output int ewb,
                            output logic [31:0] ewba, output int efill, output string wtag,
                            output string ftag);
    int idx = int'(a[9:5]);
    int w = int'(a[4:2]);
    logic [31:0] b = {a[31:5], 5'b0};
    logic [31:0] vb;
    ewb = 0; efill = 0; ewba = 0; wtag = "R8"; ftag = "R6";
    ehit = r_vld[idx] && r_tag[idx] == a[31:10];
    if (!ehit) begin
      vb = {r_tag[idx], 5'(idx), 5'b0};
      if (r_vld[idx] && r_dty[idx]) begin
        if ({1'b0, vb} + 33'd32 <= {1'b0, r_tos}) wtag = "R4";
        else begin
          wtag = "R3"; ewb = 1; ewba = vb;
          ref_mem[li(vb)] = r_line[idx];
        end
      end
      if (we && b >= r_tos && {1'b0, b} + 33'd32 <= {1'b0, r_srb}) begin
        r_line[idx] = '0; ftag = "R5";
      end else begin
        r_line[idx] = ref_mem[li(b)]; efill = 1;
        if (!we) ftag = "R2";
      end
      r_tag[idx] = a[31:10]; r_vld[idx] = 1'b1; r_dty[idx] = 1'b0;
    end
    erd = r_line[idx][w*32 +: 32];
    if (we) begin
      r_line[idx][w*32 +: 32] = wd;
      r_dty[idx] = 1'b1;
    end
  endtask

  task automatic op(input bit we, input logic [31:0] a, input logic [31:0] wd,
                    output logic [31:0] got);
    logic [31:0] erd, ewba;
    bit ehit;
    int ewb, efill, wb0, f0, cyc;
    string wtag, ftag;
    ref_access(we, a, wd, erd, ehit, ewb, ewba, efill, wtag, ftag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    wb0 = wb_cnt; f0 = fill_cnt;
    req_valid = 1; req_write = we; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    cyc = 1;
    while (!rsp_valid) begin @(negedge clk); cyc++; end
    got = rsp_rdata;
    if (!we) check(got == erd, ehit ? "R1" : ftag, got, erd, "load data");
    if (ehit) check(cyc == 2 && wb_cnt == wb0 && fill_cnt == f0, "R1", cyc, 2, "hit latency");
    check(wb_cnt - wb0 == ewb, wtag, wb_cnt - wb0, ewb, "write-back count");
    if (ewb == 1) check(wb_last == ewba, "R3", wb_last, ewba, "write-back address");
    check(fill_cnt - f0 == efill, ftag, fill_cnt - f0, efill, "fill count");
  endtask

  task automatic stack_evt(input bit is_call, input logic [31:0] sp);
    @(negedge clk);
    call_evt = is_call; ret_evt = !is_call; sp_new = sp;
    @(negedge clk);
    call_evt = 0; ret_evt = 0;
    r_tos = sp;
    if (!is_call) r_srb = sp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] g, sp;
    void'($urandom(32'd7));
    for (int i = 0; i < NL; i++) begin mem_m[i] = init_line(i); ref_mem[i] = init_line(i); end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready && !mem_valid && !rsp_valid, "R10", {req_ready, mem_valid, rsp_valid}, 3'b100, "reset outputs");
    rst_n = 1;

    stack_evt(0, 32'h1C00);
    stack_evt(1, 32'h1800);
    op(1, 32'h1904, 32'hDEAD_0001, g);
    op(0, 32'h1908, 0, g);
    check(g == 0, "R5", g, 0, "fresh line other word");
    op(0, 32'h1904, 0, g);
    check(g == 32'hDEAD_0001, "R7", g, 32'hDEAD_0001, "call kept srb, store kept");
    op(1, 32'h1908, 32'h0000_BEEF, g);
    op(0, 32'h190C, 0, g);
    op(1, 32'h1E04, 32'h1234_5678, g);
    op(0, 32'h1E08, 0, g);
    check(g == init_line(li(32'h1E00))[2*32 +: 32], "R6", g, init_line(li(32'h1E00))[2*32 +: 32], "merged fill");
    op(0, 32'h1D00, 0, g);
    check(mem_m[li(32'h1900)][32 +: 32] == 32'hDEAD_0001, "R3", mem_m[li(32'h1900)][32 +: 32], 32'hDEAD_0001, "live victim stored");
    op(1, 32'h1910, 32'h5555_AAAA, g);
    stack_evt(0, 32'h1C00);
    op(0, 32'h1D04, 0, g);
    check(mem_m[li(32'h1900)][4*32 +: 32] != 32'h5555_AAAA, "R4", mem_m[li(32'h1900)][4*32 +: 32], 0, "dead victim discarded");
    op(1, 32'h1A00, 32'h7777_0000, g);
    op(0, 32'h1A04, 0, g);
    check(g == init_line(li(32'h1A00))[32 +: 32], "R7", g, init_line(li(32'h1A00))[32 +: 32], "return emptied fresh region");
    op(0, 32'h1A00, 0, g);

    for (int n = 0; n < 2500; n++) begin
      int r = int'($urandom % 16);
      if (r == 0 && r_tos >= 32'h1100) begin
        sp = r_tos - 4 * (1 + $urandom % 64);
        stack_evt(1, sp);
      end else if (r == 1 && r_tos <= 32'h1F00) begin
        sp = r_tos + 4 * (1 + $urandom % 64);
        stack_evt(0, sp);
      end else
        op(bit'($urandom % 2), BASE_A + 4 * ($urandom % 1024), $urandom, g);
    end

    repeat (4) @(negedge clk);
    for (int i = 0; i < NL; i++)
      check(mem_m[i] == ref_mem[i], "R3", mem_m[i][31:0], ref_mem[i][31:0], "backing line contents");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule